// File: doc/BRIEF.md
# Outstanding-Miss Tracking Table

This block keeps track of cache-line misses that have gone out to the next memory level and have not yet come back. It holds a small, fully associative table of entries. Each entry carries a block address, a set of flags (line fill, no-allocate, uncacheable), an owner thread or a shared marker, an age stamp, and a short list of waiting requesters, called targets. A new miss first searches the table. If a live entry covers the same block, the miss joins that entry as one more target. Otherwise the miss takes a free entry.

The block presents one pending entry at a time to the bus side through the issue port. The bus side accepts it with `iss_take`, which moves the entry into service. A fill response for an in-service entry retires some or all of its targets. An entry that still holds targets afterwards is sent again. A squash removes every entry owned by one thread. Three level outputs report the state to the cache: a bus request, table full, and target list full.

Each entry is a three-state machine:
- `ST_FREE` moves to `ST_WAIT` on *alloc*.
- `ST_WAIT` moves to `ST_BUSY` on *take*.
- `ST_BUSY` moves to `ST_WAIT` on *reissue*, or to `ST_FREE` on *retire*.
- *Squash* moves `ST_WAIT` or `ST_BUSY` to `ST_FREE`.

Only one operation takes effect in a cycle, in this priority order: squash, fill, take, request.

Top module: `mshr_file`

## Requirements
- R1: The block address is the request address with its low log2(BLK_BYTES) bits forced to zero. A cacheable request whose block address equals that of a live cacheable entry merges into that entry: `lk_hit`=1, `req_idx` is that entry, and no new entry is taken. Otherwise the request takes the lowest-numbered free entry.
- R2: An uncacheable request never matches and always takes a fresh entry, with line_fill=0 and uncache=1. Uncacheable entries are never matched by later requests. A cacheable allocation sets line_fill=1.
- R3: Merging a request from a thread other than the entry's owner sets the entry's shared marker (`iss_shared`=1).
- R4: Merging an allocating request (`req_noalloc`=0) into an entry flagged no-allocate clears that flag.
- R5: When a merge brings an entry's target count to NUM_TARGETS, the following behaviour holds:
  - `blk_no_targets` rises.
  - That entry is presented on the issue port ahead of older entries.
  - `req_ready` stays low while `blk_no_targets` is high.
  - A fill to that entry, or a squash that removes it, drops `blk_no_targets`.
- R6: Allocating the last free entry raises `blk_no_entries`. While it is high, a request that does not match has `req_ready`=0. It falls only when an entry is freed.
- R7: Every allocation and every reissue stamps the entry with the global order counter, which starts at 0 after reset and then increments. The issue port shows the waiting entry with the smallest stamp, unless an entry has been moved to the front.
- R8: `bus_req` rises on any allocation whose command is not hardware prefetch (command code 3; 0=read, 1=write, 2=software prefetch). A hardware-prefetch allocation leaves `bus_req` unchanged. A take that leaves no other waiting entry drops `bus_req`.
- R9: A fill retires `fill_nret` targets, capped at the target count; an uncacheable or no-allocate entry retires all of them. If targets remain, the entry returns to waiting with the next target's command, takes a new stamp and raises `bus_req`. Otherwise the entry is freed.
- R10: A squash for thread T frees every unshared entry owned by T and releases a full-target block held by such an entry. It drops `bus_req` when no waiting entry survives.
- R11: After reset, the outputs are in the following state:
  - `bus_req`, `blk_no_entries`, `blk_no_targets` and `iss_valid` are all 0.
  - `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A miss request is presented |
| req_addr | input | ADDR_W | Request byte address |
| req_cmd | input | 2 | 0 read, 1 write, 2 software prefetch, 3 hardware prefetch |
| req_thread | input | THR_W | Requesting thread |
| req_uncache | input | 1 | Request is uncacheable |
| req_noalloc | input | 1 | Request must not allocate in the cache |
| req_ready | output | 1 | Request would be accepted this cycle |
| lk_hit | output | 1 | Request matches a live entry |
| req_idx | output | IDX_W | Entry that would merge or allocate |
| iss_valid | output | 1 | A waiting entry is offered |
| iss_idx | output | IDX_W | Offered entry |
| iss_addr | output | ADDR_W | Offered block address |
| iss_cmd | output | 2 | Offered command |
| iss_thread | output | THR_W | Offered owner thread |
| iss_shared | output | 1 | Offered entry has several owners |
| iss_line_fill | output | 1 | Offered entry fills a line |
| iss_noalloc | output | 1 | Offered entry is no-allocate |
| iss_uncache | output | 1 | Offered entry is uncacheable |
| iss_order | output | ORD_W | Offered entry's age stamp |
| iss_take | input | 1 | Bus side takes the offered entry |
| fill_valid | input | 1 | Fill response arrives |
| fill_idx | input | IDX_W | Entry the fill belongs to |
| fill_nret | input | CNT_W | Targets satisfied by the fill |
| squash_valid | input | 1 | Squash request |
| squash_thread | input | THR_W | Thread to squash |
| bus_req | output | 1 | Bus request level |
| blk_no_entries | output | 1 | Table full |
| blk_no_targets | output | 1 | An entry's target list is full |

## Verification
The bench uses the default build: four entries, four targets per entry, 64-byte blocks, four threads and a 16-bit order counter. With four entries, a short directed sequence can fill the table and set `blk_no_entries`. With four targets, three merges are enough to reach the target cap. This also lets the moved-to-front entry be shown overtaking an older waiting hardware prefetch. Sixty-four-byte blocks let merges use offsets 0x04 to 0x30 inside one line. The stamps stay far below the counter's wrap point, so age order is plain numeric order.

// File: rtl/mshr_pkg.sv
`timescale 1ns/1ps
package mshr_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BUSY = 2'd2
    } ent_st_e;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_SWPF  = 2'd2,
        CMD_HWPF  = 2'd3
    } req_cmd_e;
endpackage

// File: rtl/mshr_entry.sv
`timescale 1ns/1ps
module mshr_entry
    import mshr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int THR_W       = 2,
    parameter int NUM_TARGETS = 4,
    parameter int ORD_W       = 16,
    parameter int CNT_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_alloc,
    input  logic              do_merge,
    input  logic              do_take,
    input  logic              do_fill,
    input  logic              do_squash,
    input  logic [ADDR_W-1:0] in_blk,
    input  req_cmd_e          in_cmd,
    input  logic [THR_W-1:0]  in_thread,
    input  logic              in_uncache,
    input  logic              in_noalloc,
    input  logic [ORD_W-1:0]  in_stamp,
    input  logic [CNT_W-1:0]  fill_nret,
    output ent_st_e           st,
    output logic [ADDR_W-1:0] blk,
    output req_cmd_e          cmd,
    output logic [THR_W-1:0]  thread,
    output logic              shared,
    output logic              line_fill,
    output logic              noalloc,
    output logic              uncache,
    output logic [ORD_W-1:0]  order,
    output logic [CNT_W-1:0]  tcount,
    output logic              reissue
);
    req_cmd_e         tgt    [NUM_TARGETS];
    req_cmd_e         tgt_sh [NUM_TARGETS];
    logic [CNT_W-1:0] ret_n;
    logic [CNT_W-1:0] remain;
    ent_st_e          st_nx;

    // Retire count and shifted target list for a fill
    always_comb begin
        if (uncache || noalloc)
            ret_n = tcount;
        else if (fill_nret > tcount)
            ret_n = tcount;
        else
            ret_n = fill_nret;
        remain  = tcount - ret_n;
        reissue = do_fill && (remain != '0);
        for (int i = 0; i < NUM_TARGETS; i++) begin
            tgt_sh[i] = CMD_READ;
            for (int k = 0; k < NUM_TARGETS; k++)
                if (k == i + int'(ret_n)) tgt_sh[i] = tgt[k];
        end
    end

    // Next-state logic of the entry machine
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_FREE: if (do_alloc) st_nx = ST_WAIT;
            ST_WAIT: begin
                if (do_squash)    st_nx = ST_FREE;
                else if (do_take) st_nx = ST_BUSY;
            end
            ST_BUSY: begin
                if (do_squash)    st_nx = ST_FREE;
                else if (do_fill) st_nx = reissue ? ST_WAIT : ST_FREE;
            end
            default: st_nx = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_FREE;
        else        st <= st_nx;
    end

    // Entry contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk       <= '0;
            cmd       <= CMD_READ;
            thread    <= '0;
            shared    <= 1'b0;
            line_fill <= 1'b0;
            noalloc   <= 1'b0;
            uncache   <= 1'b0;
            order     <= '0;
            tcount    <= '0;
            for (int i = 0; i < NUM_TARGETS; i++) tgt[i] <= CMD_READ;
        end else if (do_alloc) begin
            blk       <= in_blk;
            cmd       <= in_cmd;
            thread    <= in_thread;
            shared    <= 1'b0;
            line_fill <= !in_uncache;
            noalloc   <= in_noalloc;
            uncache   <= in_uncache;
            order     <= in_stamp;
            tcount    <= CNT_W'(1);
            for (int i = 0; i < NUM_TARGETS; i++)
                tgt[i] <= (i == 0) ? in_cmd : CMD_READ;
        end else if (do_merge) begin
            tcount <= tcount + CNT_W'(1);
            for (int i = 0; i < NUM_TARGETS; i++)
                if (CNT_W'(i) == tcount) tgt[i] <= in_cmd;
            if (in_thread != thread) shared  <= 1'b1;
            if (!in_noalloc)         noalloc <= 1'b0;
        end else if (reissue && !do_squash) begin
            cmd    <= tgt_sh[0];
            order  <= in_stamp;
            tcount <= remain;
            for (int i = 0; i < NUM_TARGETS; i++) tgt[i] <= tgt_sh[i];
        end else if (st_nx == ST_FREE && st != ST_FREE) begin
            tcount <= '0;
        end
    end

    // R9: a free entry holds no targets
    p_free_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FREE) |-> (tcount == '0));
    // R1: merges land only on live entries
    p_merge_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        do_merge |-> (st != ST_FREE));
endmodule

// File: rtl/mshr_pick.sv
`timescale 1ns/1ps
module mshr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int ORD_W = 16
) (
    input  logic [N-1:0]     pend,
    input  logic [ORD_W-1:0] ord [N],
    input  logic             front_v,
    input  logic [IDX_W-1:0] front_idx,
    output logic             pick_v,
    output logic [IDX_W-1:0] pick_idx
);
    logic             found;
    logic [ORD_W-1:0] best;

    always_comb begin
        pick_v   = |pend;
        pick_idx = '0;
        found    = 1'b0;
        best     = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && (!found || ord[i] < best)) begin
                found    = 1'b1;
                best     = ord[i];
                pick_idx = IDX_W'(i);
            end
        end
        if (front_v && pend[front_idx]) pick_idx = front_idx;
    end
endmodule

// File: rtl/mshr_file.sv
`timescale 1ns/1ps
module mshr_file
    import mshr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLK_BYTES   = 64,
    parameter int NUM_ENTRIES = 4,
    parameter int NUM_TARGETS = 4,
    parameter int THR_W       = 2,
    parameter int ORD_W       = 16,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CNT_W      = $clog2(NUM_TARGETS + 1),
    localparam int OFF_W      = $clog2(BLK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_cmd,
    input  logic [THR_W-1:0]  req_thread,
    input  logic              req_uncache,
    input  logic              req_noalloc,
    output logic              req_ready,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  req_idx,
    output logic              iss_valid,
    output logic [IDX_W-1:0]  iss_idx,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [1:0]        iss_cmd,
    output logic [THR_W-1:0]  iss_thread,
    output logic              iss_shared,
    output logic              iss_line_fill,
    output logic              iss_noalloc,
    output logic              iss_uncache,
    output logic [ORD_W-1:0]  iss_order,
    input  logic              iss_take,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [CNT_W-1:0]  fill_nret,
    input  logic              squash_valid,
    input  logic [THR_W-1:0]  squash_thread,
    output logic              bus_req,
    output logic              blk_no_entries,
    output logic              blk_no_targets
);
    ent_st_e           ent_st   [NUM_ENTRIES];
    logic [ADDR_W-1:0] ent_blk  [NUM_ENTRIES];
    req_cmd_e          ent_cmd  [NUM_ENTRIES];
    logic [THR_W-1:0]  ent_thr  [NUM_ENTRIES];
    logic [ORD_W-1:0]  ent_ord  [NUM_ENTRIES];
    logic [CNT_W-1:0]  ent_cnt  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] ent_shared, ent_lf, ent_na, ent_unc, ent_reissue;
    logic [NUM_ENTRIES-1:0] hit_vec, pend, sq_vec;

    logic [ADDR_W-1:0] req_blk;
    logic [IDX_W-1:0]  lk_idx, free_idx;
    logic              free_any, fill_ok, take_ok, req_go, do_alloc, do_merge;
    logic              pend_survive, pend_other;
    logic [IDX_W:0]    n_free;
    logic [ORD_W-1:0]  ord_q;
    logic [IDX_W-1:0]  nt_idx, front_idx;
    logic              front_v;
    req_cmd_e          in_cmd;

    assign in_cmd  = req_cmd_e'(req_cmd);
    assign req_blk = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    // Parallel lookup, free search and squash selection
    always_comb begin
        lk_idx   = '0;
        free_idx = '0;
        free_any = 1'b0;
        n_free   = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            hit_vec[i] = (ent_st[i] != ST_FREE) && !ent_unc[i] && !req_uncache
                         && (ent_blk[i] == req_blk);
            pend[i]    = (ent_st[i] == ST_WAIT);
            sq_vec[i]  = squash_valid && (ent_st[i] != ST_FREE) && !ent_shared[i]
                         && (ent_thr[i] == squash_thread);
            if (hit_vec[i]) lk_idx = IDX_W'(i);
            if (ent_st[i] == ST_FREE) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
                n_free   = n_free + 1'b1;
            end
        end
        lk_hit       = |hit_vec;
        pend_survive = |(pend & ~sq_vec);
        pend_other   = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++)
            if (pend[i] && IDX_W'(i) != iss_idx) pend_other = 1'b1;
    end

    // Operation decode: squash, fill, take, request
    assign fill_ok   = !squash_valid && fill_valid && (ent_st[fill_idx] == ST_BUSY);
    assign take_ok   = !squash_valid && !fill_valid && iss_take && iss_valid;
    assign req_ready = !squash_valid && !fill_valid && !iss_take && !blk_no_targets
                       && (lk_hit || (!blk_no_entries && free_any));
    assign req_go    = req_valid && req_ready;
    assign do_merge  = req_go && lk_hit;
    assign do_alloc  = req_go && !lk_hit;
    assign req_idx   = lk_hit ? lk_idx : free_idx;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        mshr_entry #(
            .ADDR_W(ADDR_W), .THR_W(THR_W), .NUM_TARGETS(NUM_TARGETS),
            .ORD_W(ORD_W), .CNT_W(CNT_W)
        ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .do_alloc  (do_alloc && free_idx == IDX_W'(g)),
            .do_merge  (do_merge && lk_idx == IDX_W'(g)),
            .do_take   (take_ok && iss_idx == IDX_W'(g)),
            .do_fill   (fill_ok && fill_idx == IDX_W'(g)),
            .do_squash (sq_vec[g]),
            .in_blk    (req_blk),
            .in_cmd    (in_cmd),
            .in_thread (req_thread),
            .in_uncache(req_uncache),
            .in_noalloc(req_noalloc),
            .in_stamp  (ord_q),
            .fill_nret (fill_nret),
            .st        (ent_st[g]),
            .blk       (ent_blk[g]),
            .cmd       (ent_cmd[g]),
            .thread    (ent_thr[g]),
            .shared    (ent_shared[g]),
            .line_fill (ent_lf[g]),
            .noalloc   (ent_na[g]),
            .uncache   (ent_unc[g]),
            .order     (ent_ord[g]),
            .tcount    (ent_cnt[g]),
            .reissue   (ent_reissue[g])
        );
    end

    mshr_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W), .ORD_W(ORD_W)) u_pick (
        .pend     (pend),
        .ord      (ent_ord),
        .front_v  (front_v),
        .front_idx(front_idx),
        .pick_v   (iss_valid),
        .pick_idx (iss_idx)
    );

    assign iss_addr      = ent_blk[iss_idx];
    assign iss_cmd       = ent_cmd[iss_idx];
    assign iss_thread    = ent_thr[iss_idx];
    assign iss_shared    = ent_shared[iss_idx];
    assign iss_line_fill = ent_lf[iss_idx];
    assign iss_noalloc   = ent_na[iss_idx];
    assign iss_uncache   = ent_unc[iss_idx];
    assign iss_order     = ent_ord[iss_idx];

    // Shared control state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ord_q          <= '0;
            bus_req        <= 1'b0;
            blk_no_entries <= 1'b0;
            blk_no_targets <= 1'b0;
            nt_idx         <= '0;
            front_v        <= 1'b0;
            front_idx      <= '0;
        end else begin
            if (do_alloc || (fill_ok && ent_reissue[fill_idx]))
                ord_q <= ord_q + 1'b1;

            if (squash_valid)
                bus_req <= bus_req && pend_survive;
            else if (fill_ok) begin
                if (ent_reissue[fill_idx]) bus_req <= 1'b1;
            end else if (take_ok)
                bus_req <= bus_req && pend_other;
            else if (do_alloc && in_cmd != CMD_HWPF)
                bus_req <= 1'b1;

            if (do_alloc && n_free == (IDX_W+1)'(1))
                blk_no_entries <= 1'b1;
            else if ((fill_ok && !ent_reissue[fill_idx]) || (|sq_vec))
                blk_no_entries <= 1'b0;

            if (squash_valid) begin
                if (blk_no_targets && sq_vec[nt_idx]) blk_no_targets <= 1'b0;
                if (front_v && sq_vec[front_idx])     front_v <= 1'b0;
            end else if (fill_ok) begin
                if (blk_no_targets && fill_idx == nt_idx) blk_no_targets <= 1'b0;
                if (front_v && fill_idx == front_idx)     front_v <= 1'b0;
            end else if (take_ok) begin
                if (front_v && iss_idx == front_idx) front_v <= 1'b0;
            end else if (do_merge && ent_cnt[lk_idx] == CNT_W'(NUM_TARGETS - 1)) begin
                blk_no_targets <= 1'b1;
                nt_idx         <= lk_idx;
                front_v        <= 1'b1;
                front_idx      <= lk_idx;
            end
        end
    end

    // R6: the full flag agrees with the count of free entries
    p_full_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_no_entries == (n_free == '0));
    // R7: the order counter moves by at most one per cycle
    p_order_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ord_q == $past(ord_q)) || (ord_q == $past(ord_q) + 1'b1));
    // R7: the offered entry is waiting
    p_issue_waiting_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (ent_st[iss_idx] == ST_WAIT));
    // R5: a target block belongs to an entry at the cap
    p_cap_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blk_no_targets |-> (ent_cnt[nt_idx] == CNT_W'(NUM_TARGETS)));
    // R8: a hardware prefetch alone does not raise the bus request
    p_hwpf_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_alloc && in_cmd == CMD_HWPF && !bus_req) |=> !bus_req);
    // R10: a squash leaving nothing waiting drops the bus request
    p_squash_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid && !pend_survive) |=> !bus_req);
endmodule

// File: tb/mshr_file_test.sv
`timescale 1ns/1ps
module mshr_file_test;
    localparam int ADDR_W = 32;
    localparam int THR_W  = 2;
    localparam int ORD_W  = 16;
    localparam int IDX_W  = 2;
    localparam int CNT_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_cmd = '0;
    logic [THR_W-1:0]  req_thread = '0;
    logic              req_uncache = 1'b0, req_noalloc = 1'b0;
    logic              req_ready, lk_hit;
    logic [IDX_W-1:0]  req_idx;
    logic              iss_valid;
    logic [IDX_W-1:0]  iss_idx;
    logic [ADDR_W-1:0] iss_addr;
    logic [1:0]        iss_cmd;
    logic [THR_W-1:0]  iss_thread;
    logic              iss_shared, iss_line_fill, iss_noalloc, iss_uncache;
    logic [ORD_W-1:0]  iss_order;
    logic              iss_take = 1'b0;
    logic              fill_valid = 1'b0;
    logic [IDX_W-1:0]  fill_idx = '0;
    logic [CNT_W-1:0]  fill_nret = '0;
    logic              squash_valid = 1'b0;
    logic [THR_W-1:0]  squash_thread = '0;
    logic              bus_req, blk_no_entries, blk_no_targets;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    mshr_file uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
        .req_thread(req_thread), .req_uncache(req_uncache), .req_noalloc(req_noalloc),
        .req_ready(req_ready), .lk_hit(lk_hit), .req_idx(req_idx),
        .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_addr(iss_addr),
        .iss_cmd(iss_cmd), .iss_thread(iss_thread), .iss_shared(iss_shared),
        .iss_line_fill(iss_line_fill), .iss_noalloc(iss_noalloc),
        .iss_uncache(iss_uncache), .iss_order(iss_order), .iss_take(iss_take),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_nret(fill_nret),
        .squash_valid(squash_valid), .squash_thread(squash_thread),
        .bus_req(bus_req), .blk_no_entries(blk_no_entries),
        .blk_no_targets(blk_no_targets)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns the lookup result seen before the edge
    task automatic put_req(input logic [31:0] a, input logic [1:0] c, input logic [1:0] t,
                           input logic unc, input logic na,
                           output logic hit, output logic [IDX_W-1:0] idx);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_thread = t;
        req_uncache = unc; req_noalloc = na;
        #1;
        hit = lk_hit; idx = req_idx;
        @(negedge clk);
        req_valid = 1'b0; req_uncache = 1'b0; req_noalloc = 1'b0;
    endtask

    task automatic take();
        iss_take = 1'b1;
        @(negedge clk);
        iss_take = 1'b0;
    endtask

    task automatic fill(input logic [IDX_W-1:0] i, input logic [CNT_W-1:0] n);
        fill_valid = 1'b1; fill_idx = i; fill_nret = n;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic squash(input logic [1:0] t);
        squash_valid = 1'b1; squash_thread = t;
        @(negedge clk);
        squash_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 bus_req", bus_req, 0);
        chk("R11 blk_no_entries", blk_no_entries, 0);
        chk("R11 blk_no_targets", blk_no_targets, 0);
        chk("R11 iss_valid", iss_valid, 0);
        chk("R11 req_ready", req_ready, 1);
    endtask

    task automatic t_merge_and_reissue();
        logic h; logic [IDX_W-1:0] x;
        put_req(32'h1004, 2'd0, 2'd0, 0, 0, h, x);
        chk("R1 first miss no hit", h, 0);
        chk("R1 first miss idx", x, 0);
        chk("R1 block address", iss_addr, 32'h1000);
        chk("R7 first stamp", iss_order, 0);
        chk("R2 cacheable line fill", iss_line_fill, 1);
        chk("R8 read raises bus_req", bus_req, 1);
        put_req(32'h1030, 2'd0, 2'd0, 0, 0, h, x);
        chk("R1 same line hit", h, 1);
        chk("R1 same line idx", x, 0);
        chk("R3 same thread not shared", iss_shared, 0);
        put_req(32'h1010, 2'd1, 2'd1, 0, 0, h, x);
        chk("R3 other thread shares", iss_shared, 1);
        put_req(32'h2000, 2'd0, 2'd0, 0, 1, h, x);
        chk("R1 new line idx", x, 1);
        chk("R7 oldest offered", iss_idx, 0);
        take();
        chk("R7 next offered", iss_idx, 1);
        chk("R4 noalloc kept", iss_noalloc, 1);
        chk("R8 bus_req held with waiter", bus_req, 1);
        put_req(32'h2008, 2'd0, 2'd0, 0, 0, h, x);
        chk("R4 noalloc upgraded", iss_noalloc, 0);
        fill(2'd0, 3'd2);
        chk("R9 reissue older first", iss_idx, 1);
        take();
        chk("R9 reissued entry offered", iss_idx, 0);
        chk("R9 next target command", iss_cmd, 2'd1);
        chk("R9 new stamp", iss_order, 2);
        take();
        chk("R8 bus_req drops when none wait", bus_req, 0);
        fill(2'd0, 3'd1);
        fill(2'd1, 3'd4);
        chk("R9 entries freed", iss_valid, 0);
        chk("R9 bus_req after frees", bus_req, 0);
        chk("R6 never full", blk_no_entries, 0);
    endtask

    task automatic t_uncache_and_full();
        logic h; logic [IDX_W-1:0] x;
        put_req(32'h3000, 2'd0, 2'd0, 1, 0, h, x);
        chk("R2 uncacheable idx", x, 0);
        put_req(32'h3000, 2'd0, 2'd1, 1, 0, h, x);
        chk("R2 uncacheable never hits", h, 0);
        chk("R2 uncacheable fresh idx", x, 1);
        put_req(32'h3004, 2'd0, 2'd1, 0, 0, h, x);
        chk("R2 cacheable skips uncacheable", h, 0);
        chk("R2 cacheable idx", x, 2);
        chk("R2 uncacheable no line fill", iss_line_fill, 0);
        chk("R2 uncacheable flag", iss_uncache, 1);
        chk("R7 stamp after reissue", iss_order, 3);
        chk("R6 not full at three", blk_no_entries, 0);
        put_req(32'h4000, 2'd3, 2'd2, 0, 0, h, x);
        chk("R6 last entry full", blk_no_entries, 1);
        req_addr = 32'h7000; req_uncache = 1'b0; #1;
        chk("R6 miss blocked", req_ready, 0);
        req_addr = 32'h3008; #1;
        chk("R6 merge still accepted", req_ready, 1);
        take();
        fill(2'd0, 3'd1);
        chk("R6 released on free", blk_no_entries, 0);
        squash(2'd1);
        chk("R10 survivor offered", iss_idx, 3);
        chk("R10 bus_req kept", bus_req, 1);
        squash(2'd2);
        chk("R10 nothing left", iss_valid, 0);
        chk("R10 bus_req dropped", bus_req, 0);
    endtask

    task automatic t_prefetch_and_cap();
        logic h; logic [IDX_W-1:0] x;
        put_req(32'h5000, 2'd3, 2'd3, 0, 0, h, x);
        chk("R8 hw prefetch no bus_req", bus_req, 0);
        chk("R8 hw prefetch offered", iss_cmd, 2'd3);
        chk("R7 stamp seven", iss_order, 7);
        put_req(32'h6000, 2'd0, 2'd0, 0, 0, h, x);
        chk("R8 read raises bus_req", bus_req, 1);
        chk("R5 new idx", x, 1);
        put_req(32'h6010, 2'd0, 2'd0, 0, 0, h, x);
        put_req(32'h6020, 2'd1, 2'd0, 0, 0, h, x);
        chk("R5 below cap", blk_no_targets, 0);
        chk("R5 older still first", iss_idx, 0);
        put_req(32'h6030, 2'd0, 2'd0, 0, 0, h, x);
        chk("R5 cap reached", blk_no_targets, 1);
        chk("R5 moved to front", iss_idx, 1);
        chk("R5 requests blocked", req_ready, 0);
        squash(2'd0);
        chk("R10 target block released", blk_no_targets, 0);
        chk("R10 other thread kept", iss_idx, 0);
        chk("R10 bus_req kept with waiter", bus_req, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge_and_reissue();
        t_uncache_and_full();
        t_prefetch_and_cap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule